// File: doc/BRIEF.md
# Paged Open-Drain I/O Bank Register File

This block puts forty-eight open-drain I/O lines behind an 8-bit host register file that spans sixteen byte offsets. The lines are grouped into six ports of eight lines each. A host write to a port byte chooses, line by line, whether the pad sinks current or floats. A floating pad is pulled high outside the chip and can then serve as an input. A host read of a port byte returns the inverted, synchronized pin level: a 1 means the pin is low.

One control byte does two jobs. It selects which of four pages appears in a three-byte window near the top of the map, and it holds one write-protect bit per port. The port bytes, the pending-status byte and the control byte can be reached on every page. The window bytes live in a companion edge-detect block. This block passes window writes to that block together with the page and byte index. It reads window contents back from a 24-bit bus that carries the three bytes of the currently selected page. The synchronized pin levels are also brought out so the companion block can use them for edge detection.

Top module: `dio_page_bank`

## Requirements
- R1: After reset, every pad is released (`pad_oe` all 0), the page is 0 and all write-protect bits are clear, so the control byte at offset 7 reads 0x00.
- R2: A write of byte D to offset k (0 to 5) sets the drive of lines 8k+b to D[b]. A 1 on `pad_oe` means the pad sinks current and the pin is low; a 0 releases the pad. `pad_oe` follows the write one clock after the write strobe.
- R3: A read of offset k (0 to 5) returns bit b as the inverse of the synchronized level of line 8k+b, so a high pin reads as 0.
- R4: Offset 7 is the control byte. Bits 7:6 select the page (0 to 3) and bit k (0 to 5) write-protects port k. It reads back exactly as it was last written.
- R5: While the write-protect bit of port k is set, writes to offset k leave that port's drive unchanged. Reads of offset k still work.
- R6: The port bytes (offsets 0 to 5), the pending byte and the control byte read and write the same way whichever page is selected.
- R7: Offset 6 reads as {5'b0, pend_in[2:0]}.
- R8: On pages 1 to 3, offsets 8, 9 and 10 map to window bytes 0, 1 and 2. A read returns `win_rdata[8i+7:8i]` for byte i. A write produces a one-cycle `win_wr` pulse one clock after the strobe, carrying `win_idx` = i and the written byte on `win_wdata`. `win_page` always shows the current page.
- R9: Offsets 11 to 15 always read 0x00, and so do offsets 8 to 10 on page 0. Writes to offsets 8 to 10 on page 0 raise no `win_wr`.
- R10: `bus_rdata` is registered. It takes the addressed value at the clock edge that samples `bus_rd` and holds that value until the next read.
- R11: Pin inputs pass through a two-stage synchronizer before they are read or sent out on `pin_sync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the 16-byte span |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Raw pin levels |
| pad_oe | output | 48 | Per-line sink enable (1 pulls pin low) |
| pin_sync | output | 48 | Synchronized pin levels for edge detection |
| pend_in | input | 3 | Pending status from the edge-detect block |
| win_page | output | 2 | Currently selected page |
| win_rdata | input | 24 | Three window bytes of the current page |
| win_wr | output | 1 | Window write pulse |
| win_idx | output | 2 | Window byte index of the write |
| win_wdata | output | 8 | Window write data |

## Verification
The bench builds the block with its default parameters: six ports of eight lines and two synchronizer stages. With these values the whole map can be reached, including every port, every write-protect bit and every page of the window, as well as the offsets that hold no register. A pad model combines random external drive with the sink enables, so reads cover both pins driven low from outside and pins pulled low by the block itself.

// File: rtl/dio_bank_pkg.sv
package dio_bank_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int PAGE_W    = 2;
  localparam int LOCK_W    = 6;
  localparam int WIN_BYTES = 3;
  localparam int WIN_IDX_W = 2;
  localparam logic [ADDR_W-1:0] OFF_PEND  = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'd7;
  localparam logic [ADDR_W-1:0] OFF_WIN_0 = 4'd8;
  localparam logic [ADDR_W-1:0] OFF_WIN_L = 4'd10;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dio_ctrl_reg.sv
module dio_ctrl_reg
  import dio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [PAGE_W-1:0] page,
  output logic [LOCK_W-1:0] lock
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata;
  end

  assign page = ctrl_q[DATA_W-1 -: PAGE_W];
  assign lock = ctrl_q[LOCK_W-1:0];

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q)); // R4
endmodule

// File: rtl/dio_port_regs.sv
module dio_port_regs #(
  parameter int NPORT = 6,
  parameter int PW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    wr_sel,
  input  logic [PW-1:0]       wdata,
  input  logic [NPORT-1:0]    lock,
  output logic [NPORT*PW-1:0] drive
);
  genvar k;
  generate
    for (k = 0; k < NPORT; k++) begin : g_port
      logic [PW-1:0] port_q;
      always_ff @(posedge clk) begin
        if (rst)                       port_q <= '0;
        else if (wr_sel[k] && !lock[k]) port_q <= wdata;
      end
      assign drive[k*PW +: PW] = port_q;

      AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_sel[k] && lock[k]) |=> $stable(drive[k*PW +: PW])); // R5
    end
  endgenerate

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel)); // R2
endmodule

// File: rtl/dio_page_bank.sv
module dio_page_bank
  import dio_bank_pkg::*;
#(
  parameter int NPORT       = 6,
  parameter int PW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NLINE      = NPORT * PW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NLINE-1:0]           pad_in,
  output logic [NLINE-1:0]           pad_oe,
  output logic [NLINE-1:0]           pin_sync,
  input  logic [2:0]                 pend_in,
  output logic [PAGE_W-1:0]          win_page,
  input  logic [WIN_BYTES*DATA_W-1:0] win_rdata,
  output logic                       win_wr,
  output logic [WIN_IDX_W-1:0]       win_idx,
  output logic [DATA_W-1:0]          win_wdata
);
  logic [DATA_W-1:0] ctrl_q;
  logic [PAGE_W-1:0] page;
  logic [LOCK_W-1:0] lock_all;
  logic [NPORT-1:0]  port_wr_sel;
  logic              ctrl_wr;
  logic              in_window;
  logic [WIN_IDX_W-1:0] cur_idx;
  logic [DATA_W-1:0] rd_mux;

  // decode
  assign ctrl_wr   = bus_wr && (bus_addr == OFF_CTRL);
  assign in_window = (bus_addr >= OFF_WIN_0) && (bus_addr <= OFF_WIN_L);
  assign cur_idx   = WIN_IDX_W'(bus_addr - OFF_WIN_0);

  genvar k;
  generate
    for (k = 0; k < NPORT; k++) begin : g_sel
      assign port_wr_sel[k] = bus_wr && (bus_addr == ADDR_W'(k));
    end
  endgenerate

  dio_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q),
    .page   (page),
    .lock   (lock_all)
  );

  dio_port_regs #(.NPORT(NPORT), .PW(PW)) u_ports (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (port_wr_sel),
    .wdata  (bus_wdata[PW-1:0]),
    .lock   (lock_all[NPORT-1:0]),
    .drive  (pad_oe)
  );

  dio_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  // read mux
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr == ADDR_W'(p)) rd_mux = DATA_W'(~pin_sync[p*PW +: PW]);
    end
    if (bus_addr == OFF_PEND) rd_mux = {5'b0, pend_in};
    if (bus_addr == OFF_CTRL) rd_mux = ctrl_q;
    if (in_window && page != '0) begin
      for (int i = 0; i < WIN_BYTES; i++) begin
        if (cur_idx == WIN_IDX_W'(i)) rd_mux = win_rdata[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // window forwarding
  always_ff @(posedge clk) begin
    if (rst) begin
      win_wr    <= 1'b0;
      win_idx   <= '0;
      win_wdata <= '0;
    end else begin
      win_wr <= bus_wr && in_window && (page != '0);
      if (bus_wr && in_window) begin
        win_idx   <= cur_idx;
        win_wdata <= bus_wdata;
      end
    end
  end

  assign win_page = page;

  AST_RST_RELEASE: assert property (@(posedge clk)
    rst |=> (pad_oe == '0)); // R1
  AST_WIN_PAGE0: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_window && page == '0) |=> !win_wr); // R9
  AST_WIN_FWD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_window && page != '0) |=> win_wr); // R8
  AST_RD_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > OFF_WIN_L) |=> (bus_rdata == '0)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/dio_page_bank_bench.sv
module dio_page_bank_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] pad_in, pad_oe, pin_sync, ext_lvl;
  logic [2:0]  pend_in;
  logic [1:0]  win_page;
  logic [23:0] win_rdata;
  logic        win_wr;
  logic [1:0]  win_idx;
  logic [7:0]  win_wdata;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [47:0] m_oe;
  logic [7:0]  m_ctrl;

  always #2 clk = ~clk;

  function automatic logic [7:0] win_byte(input logic [1:0] pg, input int i);
    return {pg, 2'(i), 4'hC};
  endfunction

  assign pad_in    = ext_lvl & ~pad_oe;
  assign win_rdata = {win_byte(win_page, 2), win_byte(win_page, 1), win_byte(win_page, 0)};

  dio_page_bank u_dio_page_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pin_sync(pin_sync), .pend_in(pend_in), .win_page(win_page), .win_rdata(win_rdata),
    .win_wr(win_wr), .win_idx(win_idx), .win_wdata(win_wdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    logic [47:0] pin = ext_lvl & ~m_oe;
    if (a < 4'd6) return ~pin[a*8 +: 8];
    if (a == 4'd6) return {5'b0, pend_in};
    if (a == 4'd7) return m_ctrl;
    if (a <= 4'd10 && m_ctrl[7:6] != 2'd0) return win_byte(m_ctrl[7:6], int'(a - 4'd8));
    return 8'h00;
  endfunction

  // write; returns win signals sampled one cycle after strobe
  task automatic bus_write(input logic [3:0] a, input logic [7:0] d,
                           output logic ww, output logic [1:0] wi, output logic [7:0] wd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    ww = win_wr; wi = win_idx; wd = win_wdata;
    if (a < 4'd6 && !m_ctrl[a]) m_oe[a*8 +: 8] = d;
    if (a == 4'd7) m_ctrl = d;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    repeat (4) @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic ww; logic [1:0] wi; logic [7:0] wd;
    void'($urandom(32'd1234));
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    ext_lvl = '1; pend_in = 3'd0; m_oe = '0; m_ctrl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pad_oe after reset", pad_oe, 48'd0);
    bus_read(4'd7, rd);
    check("R1 ctrl after reset", rd, 8'h00);

    // directed: drive port 2, read inverted
    bus_write(4'd2, 8'hA5, ww, wi, wd);
    check("R2 pad_oe port2", pad_oe, m_oe);
    bus_read(4'd2, rd);
    check("R3 port2 read", rd, 8'hA5);
    ext_lvl[0 +: 8] = 8'h0F;
    bus_read(4'd0, rd);
    check("R3 external low reads 1", rd, 8'hF0);
    ext_lvl = '1;

    // lock port 2
    bus_write(4'd7, 8'h04, ww, wi, wd);
    bus_write(4'd2, 8'h3C, ww, wi, wd);
    check("R5 locked port unchanged", pad_oe[23:16], 8'hA5);
    bus_read(4'd2, rd);
    check("R5 locked port readable", rd, 8'hA5);

    // page 0 window
    bus_write(4'd9, 8'h55, ww, wi, wd);
    check("R9 no win_wr on page0", ww, 1'b0);
    bus_read(4'd9, rd);
    check("R9 window page0 reads 0", rd, 8'h00);

    // page 3 window
    bus_write(4'd7, 8'hC0, ww, wi, wd);
    bus_write(4'd10, 8'h77, ww, wi, wd);
    check("R8 win_wr pulse", ww, 1'b1);
    check("R8 win_idx", wi, 2'd2);
    check("R8 win_wdata", wd, 8'h77);
    check("R8 win_page", win_page, 2'd3);
    @(negedge clk);
    check("R8 win_wr one cycle", win_wr, 1'b0);
    bus_read(4'd8, rd);
    check("R8 window read byte0", rd, win_byte(2'd3, 0));
    bus_read(4'd15, rd);
    check("R9 offset 15 reads 0", rd, 8'h00);
    pend_in = 3'd5;
    bus_read(4'd6, rd);
    check("R7 pending on page3", rd, 8'h05);
    bus_write(4'd1, 8'hFF, ww, wi, wd);
    check("R6 port write on page3", pad_oe[15:8], 8'hFF);
    bus_read(4'd7, rd);
    check("R4 ctrl readback", rd, 8'hC0);

    // hold of read data
    repeat (3) @(negedge clk);
    check("R10 rdata held", bus_rdata, 8'hC0);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 5);
      logic [3:0] a;
      if ($urandom_range(0, 7) == 0) ext_lvl = {$urandom, $urandom} | {$urandom, $urandom};
      pend_in = 3'($urandom);
      case (op)
        0, 1: begin
          a = 4'($urandom_range(0, 5));
          bus_write(a, 8'($urandom), ww, wi, wd);
          check("R2 R5 pad_oe", pad_oe, m_oe);
        end
        2: begin
          bus_write(4'd7, {2'($urandom), 6'($urandom & $urandom & $urandom)}, ww, wi, wd);
          check("R4 page", win_page, m_ctrl[7:6]);
        end
        3: begin
          a = 4'($urandom_range(8, 10));
          bus_write(a, 8'($urandom), ww, wi, wd);
          check("R8 R9 win_wr", ww, m_ctrl[7:6] != 2'd0);
          if (ww) check("R8 win_idx", wi, a - 4'd8);
        end
        default: begin
          a = 4'($urandom_range(0, 15));
          bus_read(a, rd);
          check("R3 R6 R7 R8 R9 read", rd, exp_read(a));
        end
      endcase
    end

    // synchronizer latency: pin change not visible one cycle later, visible after two
    bus_write(4'd7, 8'h00, ww, wi, wd);
    bus_write(4'd5, 8'h00, ww, wi, wd);
    ext_lvl[47:40] = 8'hFF;
    repeat (4) @(negedge clk);
    ext_lvl[47:40] = 8'h00;
    @(negedge clk);
    check("R11 sync stage 1", pin_sync[47:40], 8'hFF);
    @(negedge clk);
    check("R11 sync stage 2", pin_sync[47:40], 8'h00);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule